// File: doc/BRIEF.md
# CORDIC Gain Compensation Scaler

This block removes the processing gain that a shift-and-add rotator puts on its vectors. It multiplies a pair of signed samples, x and y, by the fixed reciprocal of that gain. The gain depends on the rotator's iteration count, which is a compile-time parameter. The scaling uses no hardware multiplier: the reciprocal is turned into a canonical signed-digit pattern at elaboration, and the shifted copies of each sample are summed through a short pipeline.

There are two typical placements:
- After a rotator in vectoring mode, where the block normalises the output magnitude.
- In front of a rotator in rotation mode, on the input magnitude, or after it, on both output coordinates.

The block takes one sample pair on every clock. A valid flag travels alongside the data with the same delay. A parameter sets how many extra fraction bits the coefficient and the internal sums carry, which controls the accuracy of the rounded result.

Top module: `cordic_gain_comp`

## Requirements
- R1: With F = W + FRAC_EXT and K(N) the product over i = 0..N-1 of sqrt(1 + 2^(-2i)), the coefficient is C = round(2^F / K(N)). The x result is floor((x*C + 2^(F-1)) / 2^F), which is rounding to nearest with ties upward, returned as a W-bit two's complement value.
- R2: The y result follows the same formula as R1, and each channel depends only on its own input.
- R3: A pair accepted on a clock edge with `in_valid` high appears on the outputs, with `out_valid` high, exactly six rising edges later, counting the capture edge.
- R4: Pairs presented on consecutive cycles come out on consecutive cycles, in order, with no gaps and no stall.
- R5: While `rst_n` is low, `out_valid`, `out_x` and `out_y` are all zero.
- R6: No result is larger in magnitude than its input, and a nonzero result has the sign of its input. This holds for the full-scale positive and most negative inputs, without saturation.
- R7: A zero input gives a zero output on that channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a sample pair to be scaled |
| in_x | input | W | Signed x sample |
| in_y | input | W | Signed y sample |
| out_valid | output | 1 | Marks a scaled pair, six cycles after its input |
| out_x | output | W | Scaled x sample |
| out_y | output | W | Scaled y sample |

## Verification
The bench aims at the values where rounding and sign handling are most fragile:
- The inputs +1 and -1: a truncating design would return 0 and -1 instead of 1 and -1.
- The most negative and full-scale inputs: a wrong sign extension of the shifted terms would wrap them into large values of the wrong sign.

A single isolated sample is followed edge by edge, so that a pipeline one stage short or long shows up as `out_valid` rising in the wrong cycle. Long back-to-back streams with different x and y data check the following:
- that the carried copies of the samples stay aligned with their partial sums, since a stage that read a newer sample would corrupt every result;
- that no value leaks from one channel into the other.

// File: rtl/cordic_gain_comp.sv
module cordic_gain_comp #(
  parameter int W        = 18,
  parameter int N_ITER   = 16,
  parameter int FRAC_EXT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  output logic         out_valid,
  output logic [W-1:0] out_x,
  output logic [W-1:0] out_y
);
  localparam int F      = W + FRAC_EXT;
  localparam int PW     = W + F + 3;
  localparam int NDIG   = F + 2;
  localparam int GRP    = (NDIG + 3) / 4;
  localparam int LAT    = 6;

  function automatic logic [F:0] coef_calc();
    logic [127:0] p, d, s, r, t;
    p = 128'd1 << 126;
    for (int i = 0; i < N_ITER; i++) begin
      d = (128'd1 << (2 * i)) + 128'd1;
      p = p - p / d;
    end
    s = p >> (124 - 2 * F);
    r = '0;
    for (int b = 63; b >= 0; b--) begin
      t = r | (128'd1 << b);
      if (t * t <= s) r = t;
    end
    r = (r + 128'd1) >> 1;
    return r[F:0];
  endfunction

  localparam logic [F:0] COEF = coef_calc();

  function automatic logic [NDIG-1:0] csd_mask(input bit want_neg);
    logic [F+2:0] c;
    logic [NDIG-1:0] m;
    c = {2'b00, COEF};
    m = '0;
    for (int j = 0; j < NDIG; j++) begin
      if (c[0]) begin
        if (c[1]) begin
          m[j] = want_neg;
          c = c + 1'b1;
        end else begin
          m[j] = !want_neg;
          c = c - 1'b1;
        end
      end
      c = c >> 1;
    end
    return m;
  endfunction

  localparam logic [NDIG-1:0] POS_D = csd_mask(1'b0);
  localparam logic [NDIG-1:0] NEG_D = csd_mask(1'b1);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (F - 1);

  logic [W-1:0] x1, y1;
  logic [LAT-1:0] vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1  <= '0;
      y1  <= '0;
      vld <= '0;
    end else begin
      x1  <= in_x;
      y1  <= in_y;
      vld <= {vld[LAT-2:0], in_valid};
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_stage
    logic [W-1:0] src_x, src_y;
    logic signed [PW-1:0] base_x, base_y, sum_x, sum_y, ex, ey;
    logic signed [PW-1:0] acc_x, acc_y;

    if (k == 0) begin : g_first
      assign src_x  = x1;
      assign src_y  = y1;
      assign base_x = '0;
      assign base_y = '0;
    end else begin : g_next
      assign src_x  = g_stage[k-1].g_carry.px;
      assign src_y  = g_stage[k-1].g_carry.py;
      assign base_x = g_stage[k-1].acc_x;
      assign base_y = g_stage[k-1].acc_y;
    end

    assign ex = {{(PW-W){src_x[W-1]}}, src_x};
    assign ey = {{(PW-W){src_y[W-1]}}, src_y};

    always_comb begin
      sum_x = base_x;
      sum_y = base_y;
      for (int j = k * GRP; j < (k + 1) * GRP && j < NDIG; j++) begin
        if (POS_D[j]) begin
          sum_x = sum_x + (ex <<< j);
          sum_y = sum_y + (ey <<< j);
        end else if (NEG_D[j]) begin
          sum_x = sum_x - (ex <<< j);
          sum_y = sum_y - (ey <<< j);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_x <= '0;
        acc_y <= '0;
      end else begin
        acc_x <= sum_x;
        acc_y <= sum_y;
      end
    end

    if (k < 3) begin : g_carry
      logic [W-1:0] px, py;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          px <= '0;
          py <= '0;
        end else begin
          px <= src_x;
          py <= src_y;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_x <= '0;
      out_y <= '0;
    end else begin
      out_x <= W'((g_stage[3].acc_x + HALF) >>> F);
      out_y <= W'((g_stage[3].acc_y + HALF) >>> F);
    end
  end

  assign out_valid = vld[LAT-1];

  function automatic logic [W:0] mag(input logic [W-1:0] v);
    logic signed [W:0] e;
    e = {v[W-1], v};
    return (e < 0) ? -e : e;
  endfunction

  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 3'd6) warm <= warm + 3'd1;
  end

  // R3
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd6) |-> (out_valid == $past(in_valid, 6)));

  // R6
  x_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd6 && out_valid) |-> (mag(out_x) <= mag($past(in_x, 6))));

  // R6
  y_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd6 && out_valid) |-> (mag(out_y) <= mag($past(in_y, 6))));

  // R6
  x_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd6 && out_valid && out_x != '0) |-> (out_x[W-1] == $past(in_x[W-1], 6)));

  // R7
  y_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd6 && out_valid && $past(in_y, 6) == '0) |-> (out_y == '0));
endmodule

// File: tb/tb_cordic_gain_comp.sv
`timescale 1ns/1ps
module tb_cordic_gain_comp;
  localparam int W = 18;
  localparam int N_ITER = 16;
  localparam int FRAC_EXT = 6;
  localparam int F = W + FRAC_EXT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_x = '0, in_y = '0;
  logic out_valid;
  logic [W-1:0] out_x, out_y;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint coef;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  cordic_gain_comp #(.W(W), .N_ITER(N_ITER), .FRAC_EXT(FRAC_EXT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y));

  function automatic longint expv(input logic [W-1:0] v);
    longint s;
    s = longint'($signed(v));
    return (s * coef + (64'sd1 <<< (F - 1))) >>> F;
  endfunction

  function automatic logic [W-1:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[W+5:6];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic chk_out(input string req, input logic [W-1:0] vx, input logic [W-1:0] vy);
    chk(out_valid == 1'b1, req, out_valid, 1);
    chk(longint'($signed(out_x)) == expv(vx), req, $signed(out_x), expv(vx));
    chk(longint'($signed(out_y)) == expv(vy), req, $signed(out_y), expv(vy));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 valid", out_valid, 0);
    chk(out_x == '0, "R5 x", $signed(out_x), 0);
    chk(out_y == '0, "R5 y", $signed(out_y), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(out_valid == 1'b0, "R5 idle after reset", out_valid, 0);
  endtask

  task automatic t_latency(input logic [W-1:0] vx, input logic [W-1:0] vy);
    @(negedge clk);
    in_valid = 1'b1; in_x = vx; in_y = vy;
    for (int c = 1; c <= 7; c++) begin
      @(negedge clk);
      if (c == 1) begin in_valid = 1'b0; in_x = '0; in_y = '0; end
      if (c < 6) chk(out_valid == 1'b0, "R3 early", out_valid, 0);
      else if (c == 6) chk_out("R3 R1 R2 single", vx, vy);
      else chk(out_valid == 1'b0, "R3 late", out_valid, 0);
    end
  endtask

  task automatic t_stream(input string req, input int n, input int kind);
    logic [W-1:0] qx [64];
    logic [W-1:0] qy [64];
    for (int c = 0; c < n + 6; c++) begin
      @(negedge clk);
      if (c >= 6) chk_out(req, qx[c-6], qy[c-6]);
      if (c < n) begin
        case (kind)
          0: begin qx[c] = rnd(); qy[c] = rnd(); end
          1: begin qx[c] = rnd(); qy[c] = '0; end
          default: begin
            case (c % 6)
              0: begin qx[c] = {1'b0, {(W-1){1'b1}}}; qy[c] = {1'b1, {(W-1){1'b0}}}; end
              1: begin qx[c] = {1'b1, {(W-1){1'b0}}}; qy[c] = {1'b0, {(W-1){1'b1}}}; end
              2: begin qx[c] = W'(1); qy[c] = {W{1'b1}}; end
              3: begin qx[c] = {W{1'b1}}; qy[c] = W'(1); end
              4: begin qx[c] = '0; qy[c] = W'(2); end
              default: begin qx[c] = W'(3); qy[c] = '0; end
            endcase
          end
        endcase
        in_valid = 1'b1; in_x = qx[c]; in_y = qy[c];
      end else begin
        in_valid = 1'b0; in_x = '0; in_y = '0;
      end
    end
  endtask

  initial begin
    real k = 1.0;
    for (int i = 0; i < N_ITER; i++) k = k * $sqrt(1.0 + 2.0 ** (-2.0 * i));
    coef = longint'($rtoi((2.0 ** F) / k + 0.5));
    repeat (3) @(negedge clk);
    t_reset();
    // R1 R6: +1 must round to 1, -1 to -1
    t_latency(W'(1), {W{1'b1}});
    // R7: zero in gives zero out on x
    t_latency('0, W'(1000));
    // R6: extremes
    t_latency({1'b1, {(W-1){1'b0}}}, {1'b0, {(W-1){1'b1}}});
    // R4 R1 R2: random back-to-back
    t_stream("R4 R1 R2 stream", 48, 0);
    // R2 R7: y held at zero while x varies
    t_stream("R2 R7 y zero", 20, 1);
    // R6 R1: boundary values back-to-back
    t_stream("R6 boundary stream", 24, 2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule